// File: doc/BRIEF.md
# Prescaled 8-bit Event Counter

This block is an 8-bit up-counter whose events come either from an instruction-cycle strobe or from edges on an external input pin. A single 8-bit prescaler sits between the event source and the counter. A mode bit hands that prescaler either to the counter, which then counts one step per 2 to 256 events, or to a neighbouring watchdog, which then gets a divided version of its own time-base events on `wd_tick`. The prescaler is never shared between the two.

The counter value can always be read, and a write loads it directly. A write also stalls counting for the next two instruction cycles. External edges pass through a two-flop synchronizer and an edge detector. Every increment waits two instruction cycles in a small delay line before it reaches the count, so the pin and the strobe see the same latency. The prescaler state cannot be seen at the ports. It is cleared when the counter is written while the prescaler belongs to the counter, and whenever the owner or the ratio code changes.

The control bits reach the block as a plain 6-bit mode input. The neighbour that holds them keeps them at all ones after reset. There is no data stream and no valid/ready handshake: a count write is a single-cycle strobe that cannot be refused.

Top module: `tick_counter8`

## Requirements
- R1: After reset, `cnt_rdata` reads 00h and `wd_tick` is low.
- R2: With mode bit 5 = 0 and bit 3 = 1 (prescaler owned by the watchdog), every `cyc_stb` is one event and adds one to the count. An event on strobe k becomes visible at strobe k+2.
- R3: A `cnt_wr` pulse loads `cnt_wdata`, and the value reads back on the next cycle. The first two strobes after the write never increment the count, and any increments already in flight are dropped.
- R4: With mode bit 3 = 0, the counter steps once per 2^(code+1) events, where code is mode bits 2:0 (000 gives 1:2, 111 gives 1:256). A count write in this mode clears the prescaler.
- R5: With mode bit 3 = 1, `wd_tick` pulses once per 2^code `wd_evt` pulses (000 gives 1:1). With bit 3 = 0, `wd_tick` repeats every `wd_evt` pulse one cycle later.
- R6: With mode bit 5 = 1, events are pin edges after a two-flop synchronizer. Mode bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges. The edge of the other polarity adds nothing.
- R7: The source that is not selected has no effect: pin activity is ignored while bit 5 = 0, and strobes alone add nothing while bit 5 = 1.
- R8: The count wraps from FFh to 00h.
- R9: A change of mode bit 3 or of bits 2:0 clears the prescaler.
- R10: Apart from a write, the count changes only on a strobe cycle, and by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One-cycle pulse per instruction cycle |
| mode_i | input | 6 | [5] external source, [4] falling edge, [3] prescaler to watchdog, [2:0] ratio code |
| pin_t | input | 1 | Asynchronous external count input |
| cnt_wr | input | 1 | Load the count from `cnt_wdata` |
| cnt_wdata | input | 8 | Value to load |
| cnt_rdata | output | 8 | Current count |
| wd_evt | input | 1 | Watchdog time-base event pulse |
| wd_tick | output | 1 | Prescaled (or passed-through) watchdog event |

## Verification
The assertions assume three things about the inputs. `cyc_stb` is a single-cycle pulse. Pin edges are spaced at least one instruction cycle apart, so that no event is merged into another while it waits for the next strobe. `wd_evt` is a single-cycle pulse. The stimulus meets these by driving one strobe every four clocks, holding each pin level for four strobes, and leaving idle clocks between watchdog pulses. Mode changes and writes are applied only between strobes. Each scenario writes the count or changes the mode first, so the state left by the previous test does not matter.

// File: rtl/tick_counter8_pkg.sv
package tick_counter8_pkg;
  typedef struct packed {
    logic       src_ext;
    logic       edge_fall;
    logic       pre_wd;
    logic [2:0] code;
  } mode_t;
endpackage

// File: rtl/tc8_edge_sync.sv
module tc8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin_async;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall})); // R6
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R6
endmodule

// File: rtl/tc8_prescaler.sv
module tc8_prescaler #(
  parameter int PRE_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_wd,
  input  logic [CODE_W-1:0] code,
  input  logic              clr,
  input  logic              src_evt,
  input  logic              wd_evt,
  output logic              tmr_tick,
  output logic              wd_tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W:0]   tmask_w;
  logic [PRE_W-1:0] tmask, wmask;
  logic             tfull, wfull, adv, wd_next;

  always_comb begin
    tmask_w = ((PRE_W+1)'(1) << (int'(code) + 1)) - (PRE_W+1)'(1);
    tmask   = tmask_w[PRE_W-1:0];
    wmask   = (PRE_W'(1) << code) - PRE_W'(1);
    tfull   = (pcnt & tmask) == tmask;
    wfull   = (pcnt & wmask) == wmask;
    adv     = pre_wd ? wd_evt : src_evt;
    tmr_tick = pre_wd ? src_evt : (src_evt & tfull);
    wd_next  = pre_wd ? (wd_evt & wfull) : wd_evt;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   pcnt <= '0;
    else if (clr) pcnt <= '0;
    else if (adv) pcnt <= pcnt + PRE_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wd_tick <= 1'b0;
    else        wd_tick <= wd_next;

  AST_WD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_wd && wd_evt) |=> wd_tick); // R5
  AST_WD_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_evt) |=> !wd_tick); // R5
  AST_TICK_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |-> src_evt); // R4
endmodule

// File: rtl/tc8_count_core.sv
module tc8_count_core #(
  parameter int CNT_W    = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_stb,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] hold;
  logic          pend, d1, d2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count <= '0;
      hold  <= '0;
      pend  <= 1'b0;
      d1    <= 1'b0;
      d2    <= 1'b0;
    end else if (wr) begin
      count <= wdata;
      hold  <= HW'(HOLD_CYC);
      pend  <= 1'b0;
      d1    <= 1'b0;
      d2    <= 1'b0;
    end else if (cyc_stb) begin
      if (d2 && hold == '0) count <= count + CNT_W'(1);
      if (hold != '0) hold <= hold - HW'(1);
      d2   <= d1;
      d1   <= pend | tick;
      pend <= 1'b0;
    end else begin
      pend <= pend | tick;
    end

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && hold != '0 && !wr) |=> (count == $past(count))); // R3
  AST_WR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (count == $past(wdata))); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_stb && !wr) |=> $stable(count)); // R10
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |=> (count == $past(count) || count == CNT_W'($past(count) + CNT_W'(1)))); // R8
endmodule

// File: rtl/tick_counter8.sv
module tick_counter8
  import tick_counter8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_stb,
  input  logic [5:0]       mode_i,
  input  logic             pin_t,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  input  logic             wd_evt,
  output logic             wd_tick
);
  mode_t      mode;
  logic [3:0] pre_cfg_q;
  logic       rise, fall, src_evt, tmr_tick, pre_clr;

  assign mode = mode_t'(mode_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_cfg_q <= 4'hF;
    else        pre_cfg_q <= {mode.pre_wd, mode.code};

  assign pre_clr = (cnt_wr && !mode.pre_wd) || (pre_cfg_q != {mode.pre_wd, mode.code});
  assign src_evt = mode.src_ext ? (mode.edge_fall ? fall : rise) : cyc_stb;

  tc8_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_t), .rise(rise), .fall(fall));

  tc8_prescaler #(.PRE_W(PRE_W), .CODE_W(3)) i_pre (
    .clk(clk), .rst_n(rst_n), .pre_wd(mode.pre_wd), .code(mode.code),
    .clr(pre_clr), .src_evt(src_evt), .wd_evt(wd_evt),
    .tmr_tick(tmr_tick), .wd_tick(wd_tick));

  tc8_count_core #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) i_core (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .tick(tmr_tick),
    .wr(cnt_wr), .wdata(cnt_wdata), .count(cnt_rdata));

  AST_EXT_NO_STB_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.src_ext && !rise && !fall) |-> !tmr_tick); // R7
endmodule

// File: tb/test_tick_counter8.sv
module test_tick_counter8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 1'b0;
  logic [5:0] mode_i = 6'h08;
  logic       pin_t = 1'b0;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wdata = 8'h00;
  logic [7:0] cnt_rdata;
  logic       wd_evt = 1'b0;
  logic       wd_tick;
  int checks = 0;
  int fails = 0;
  int wd_seen = 0;
  bit wd_count_en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_counter8 i_tick_counter8 (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .mode_i(mode_i), .pin_t(pin_t),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .wd_evt(wd_evt), .wd_tick(wd_tick));

  always @(negedge clk) if (wd_count_en && wd_tick) wd_seen++;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cyc_stb = 1'b1;
      @(negedge clk) cyc_stb = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic write_cnt(logic [7:0] v);
    @(negedge clk) begin cnt_wr = 1'b1; cnt_wdata = v; end
    @(negedge clk) cnt_wr = 1'b0;
  endtask

  task automatic set_mode(logic [5:0] m);
    @(negedge clk) mode_i = m;
    @(negedge clk);
  endtask

  task automatic wd_pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wd_evt = 1'b1;
      @(negedge clk) wd_evt = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 count after reset", cnt_rdata, 8'h00);
    chk("R1 wd_tick after reset", wd_tick, 0);
  endtask

  task automatic t_undivided;
    set_mode(6'h08);
    write_cnt(8'h10);
    chk("R3 readback", cnt_rdata, 8'h10);
    strobes(2);
    chk("R3 holdoff two strobes", cnt_rdata, 8'h10);
    strobes(8);
    chk("R2 undivided count", cnt_rdata, 8'h18);
  endtask

  task automatic t_wrap;
    set_mode(6'h08);
    write_cnt(8'hFE);
    strobes(5);
    chk("R8 wrap past FF", cnt_rdata, 8'h01);
  endtask

  task automatic t_div;
    set_mode(6'h00);
    write_cnt(8'h00);
    strobes(10);
    chk("R4 ratio 1:2", cnt_rdata, 8'h04);
    set_mode(6'h01);
    write_cnt(8'h40);
    strobes(20);
    chk("R4 ratio 1:4", cnt_rdata, 8'h44);
    set_mode(6'h07);
    write_cnt(8'h00);
    strobes(257);
    chk("R4 ratio 1:256 before tick", cnt_rdata, 8'h00);
    strobes(1);
    chk("R4 ratio 1:256 first tick", cnt_rdata, 8'h01);
  endtask

  task automatic t_mode_clear;
    set_mode(6'h01);
    write_cnt(8'h00);
    strobes(3);
    set_mode(6'h09);
    set_mode(6'h01);
    strobes(4);
    chk("R9 prescaler cleared on mode change", cnt_rdata, 8'h00);
    strobes(2);
    chk("R9 first tick after clear", cnt_rdata, 8'h01);
  endtask

  task automatic t_watchdog;
    set_mode(6'h00);
    wd_seen = 0; wd_count_en = 1'b1;
    wd_pulses(3);
    repeat (2) @(negedge clk);
    wd_count_en = 1'b0;
    chk("R5 pass-through when timer owns prescaler", wd_seen, 3);
    set_mode(6'h0A);
    wd_seen = 0; wd_count_en = 1'b1;
    wd_pulses(8);
    repeat (2) @(negedge clk);
    wd_count_en = 1'b0;
    chk("R5 watchdog ratio 1:4", wd_seen, 2);
    set_mode(6'h08);
    wd_seen = 0; wd_count_en = 1'b1;
    wd_pulses(3);
    repeat (2) @(negedge clk);
    wd_count_en = 1'b0;
    chk("R5 watchdog ratio 1:1", wd_seen, 3);
  endtask

  task automatic t_external;
    set_mode(6'h28);
    write_cnt(8'h00);
    strobes(3);
    for (int i = 0; i < 3; i++) begin
      pin_t = 1'b1; strobes(4);
      pin_t = 1'b0; strobes(4);
    end
    chk("R6 rising edges counted", cnt_rdata, 8'h03);
    set_mode(6'h38);
    pin_t = 1'b1; strobes(4);
    chk("R6 rising edge ignored in falling mode", cnt_rdata, 8'h03);
    pin_t = 1'b0; strobes(4);
    chk("R6 falling edge counted", cnt_rdata, 8'h04);
    strobes(6);
    chk("R7 strobes ignored with pin source", cnt_rdata, 8'h04);
  endtask

  task automatic t_pin_ignored;
    set_mode(6'h08);
    write_cnt(8'h20);
    for (int i = 0; i < 10; i++) begin
      pin_t = ~pin_t;
      strobes(1);
    end
    chk("R7 pin ignored with strobe source", cnt_rdata, 8'h28);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_undivided;
    t_wrap;
    t_div;
    t_mode_clear;
    t_watchdog;
    t_external;
    t_pin_ignored;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule